// File: doc/BRIEF.md
# Interleaved Block Refill Memory Controller

This block fetches a four-word cache block from main memory for a cache that has missed. Main memory sits behind a clocked bus that moves one word per bus cycle, and the whole block runs on that bus clock. A requester presents a block address with a one-cycle request strobe. The controller then spends one cycle sending the address, waits for the memory access latency, and hands the four words back one per cycle. A one-cycle done pulse marks the last word.

A parameter selects how the memory behind the bus is organised. In the banked organisation the memory has four banks, one per word of the block. All four accesses start together, so the access latency is paid once. In the narrow organisation a single word-wide memory serves each word in turn, so every word pays the full latency. The controller measures how many bus cycles each refill kept it busy. It reports that figure so the two organisations can be compared at the ports.

Memory content is modelled as a fixed function of the word address. The word at word address w is (w × 0x9E3779B1) XOR 0x5A5A0000, truncated to the data width. The word address is the block address with the two-bit word index appended below it.

Top module: `block_refill_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `rd_valid` and `done` are low, `rd_data` is zero and `last_cycles` is zero.
- R2: With the narrow organisation (`INTERLEAVED`=0), a refill keeps `busy` high for exactly 65 cycles: 1 address cycle plus 4 × (15 access cycles + 1 transfer cycle). `last_cycles` reads 65 once `busy` has fallen.
- R3: With the banked organisation (`INTERLEAVED`=1), a refill keeps `busy` high for exactly 20 cycles: 1 address cycle + 15 access cycles + 4 transfer cycles. `last_cycles` reads 20 once `busy` has fallen.
- R4: The words come back in index order 0, 1, 2, 3 on `rd_idx`. While `rd_valid` is high, `rd_data` is the model word for word address {block address, `rd_idx`}. `rd_valid` is never high while `busy` is low.
- R5: Counting the first busy cycle as cycle 1, the word with index i appears in cycle 17 + i with the banked organisation and in cycle 17 + 16·i with the narrow one.
- R6: A request that arrives while `busy` is high is ignored. The refill in progress keeps its block address and its length, and no second refill follows it.
- R7: `done` is high for exactly one cycle per refill, and that cycle is the one that carries the word with index 3.
- R8: `busy` falls in the cycle right after `done`. A request made in that cycle is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Refill request strobe, taken only while idle |
| req_blk | input | BLK_W (28) | Block address of the requested refill |
| busy | output | 1 | High from the cycle after acceptance until the last word |
| rd_valid | output | 1 | A returned word is on `rd_data` |
| rd_idx | output | IDX_W (2) | Index within the block of the returned word |
| rd_data | output | DATA_W (32) | Returned word, zero when `rd_valid` is low |
| done | output | 1 | One-cycle pulse with the last word |
| last_cycles | output | CNT_W (16) | Busy cycles taken by the most recent refill |

## Verification
On every cycle the checker confirms several properties. `done` lasts one cycle, comes with the last word, and is followed by `busy` falling. Word indices rise in order within a refill. `rd_valid` never appears while idle. The latched block address holds steady for the whole refill. Whenever `busy` falls, the measured penalty matches the organisation's formula. Other behaviour needs the bench's scenarios: the exact cycle each word appears, the data values for several block addresses (including the all-ones and the 1200-byte example block), and the ignoring of a request made during a refill. The bench checks both organisations side by side, and it also checks that a request made straight after `done` starts a new refill.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_ACCESS = 2'd2,
    PH_XFER   = 2'd3
  } phase_e;

  // Bus cycles one refill occupies for a given organisation.
  function automatic int refill_cycles(input bit banked, input int words,
                                       input int addr_cyc, input int lat,
                                       input int xfer);
    if (banked) return addr_cyc + lat + words * xfer;
    else        return addr_cyc + words * (lat + xfer);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Content model of main memory: a fixed hash of the word address.
  function automatic logic [63:0] mem_word(input logic [63:0] waddr);
    return (waddr * 64'h0000_0000_9E37_79B1) ^ 64'h0000_0000_5A5A_0000;
  endfunction

endpackage

// File: rtl/refill_sequencer.sv
module refill_sequencer
  import refill_pkg::*;
#(
  parameter int BLOCK_WORDS = 4,
  parameter int ADDR_CYC    = 1,
  parameter int BANK_LAT    = 15,
  parameter int XFER_CYC    = 1,
  parameter bit INTERLEAVED = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output phase_e                         phase,
  output logic [$clog2(BLOCK_WORDS)-1:0] word_idx,
  output logic                           access_end,
  output logic                           word_fire,
  output logic                           last_word
);

  localparam int IDX_W   = $clog2(BLOCK_WORDS);
  localparam int TMR_MAX = max3(ADDR_CYC, BANK_LAT, XFER_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  phase_e             phase_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [IDX_W-1:0]   idx_q;
  logic               tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_ADDR;
            tmr_q   <= TMR_W'(ADDR_CYC - 1);
            idx_q   <= '0;
          end
        end
        PH_ADDR: begin
          if (tmr_zero) begin
            phase_q <= PH_ACCESS;
            tmr_q   <= TMR_W'(BANK_LAT - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        PH_ACCESS: begin
          if (tmr_zero) begin
            phase_q <= PH_XFER;
            tmr_q   <= TMR_W'(XFER_CYC - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        PH_XFER: begin
          if (tmr_zero) begin
            if (last_word) begin
              phase_q <= PH_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              if (INTERLEAVED) begin
                phase_q <= PH_XFER;
                tmr_q   <= TMR_W'(XFER_CYC - 1);
              end else begin
                phase_q <= PH_ACCESS;
                tmr_q   <= TMR_W'(BANK_LAT - 1);
              end
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign word_idx   = idx_q;
  assign access_end = (phase_q == PH_ACCESS) && tmr_zero;
  assign word_fire  = (phase_q == PH_XFER) && tmr_zero;
  assign last_word  = (idx_q == IDX_W'(BLOCK_WORDS - 1));

endmodule

// File: rtl/refill_banks.sv
module refill_banks #(
  parameter int BLOCK_WORDS = 4,
  parameter int DATA_W      = 32,
  parameter int BLK_W       = 28,
  parameter bit INTERLEAVED = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fetch,
  input  logic [BLK_W-1:0]               blk,
  input  logic [$clog2(BLOCK_WORDS)-1:0] idx,
  output logic [DATA_W-1:0]              rd_data
);

  localparam int IDX_W = $clog2(BLOCK_WORDS);

  function automatic logic [DATA_W-1:0] word_at(input logic [BLK_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    return DATA_W'(refill_pkg::mem_word(64'({b, i})));
  endfunction

  generate
    if (INTERLEAVED) begin : g_banked
      logic [DATA_W-1:0] bank_rd [BLOCK_WORDS];
      for (genvar b = 0; b < BLOCK_WORDS; b++) begin : g_bank
        logic [DATA_W-1:0] bank_q;
        // Every bank completes its access on the same edge.
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     bank_q <= '0;
          else if (fetch) bank_q <= word_at(blk, IDX_W'(b));
        end
        assign bank_rd[b] = bank_q;
      end
      assign rd_data = bank_rd[idx];
    end else begin : g_narrow
      logic [DATA_W-1:0] word_q;
      // One word-wide memory: each access delivers only the current word.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word_q <= '0;
        else if (fetch) word_q <= word_at(blk, idx);
      end
      assign rd_data = word_q;
    end
  endgenerate

endmodule

// File: rtl/refill_penalty_counter.sv
module refill_penalty_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             done,
  output logic [CNT_W-1:0] last_cycles
);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= '0;
    end else if (busy) begin
      if (done) begin
        last_q <= run_q + 1'b1;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign last_cycles = last_q;

endmodule

// File: rtl/block_refill_ctrl.sv
module block_refill_ctrl
  import refill_pkg::*;
#(
  parameter int BLOCK_WORDS = 4,
  parameter int DATA_W      = 32,
  parameter int BLK_W       = 28,
  parameter int ADDR_CYC    = 1,
  parameter int BANK_LAT    = 15,
  parameter int XFER_CYC    = 1,
  parameter int CNT_W       = 16,
  parameter bit INTERLEAVED = 1'b1,
  localparam int IDX_W      = $clog2(BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BLK_W-1:0]  req_blk,
  output logic              busy,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [CNT_W-1:0]  last_cycles
);

  phase_e            phase;
  logic              start;
  logic              access_end;
  logic              word_fire;
  logic              last_word;
  logic [IDX_W-1:0]  word_idx;
  logic [BLK_W-1:0]  held_base;
  logic [DATA_W-1:0] bank_data;

  assign busy  = (phase != PH_IDLE);
  assign start = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_base <= '0;
    else if (start) held_base <= req_blk;
  end

  refill_sequencer #(
    .BLOCK_WORDS (BLOCK_WORDS),
    .ADDR_CYC    (ADDR_CYC),
    .BANK_LAT    (BANK_LAT),
    .XFER_CYC    (XFER_CYC),
    .INTERLEAVED (INTERLEAVED)
  ) seq_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .phase      (phase),
    .word_idx   (word_idx),
    .access_end (access_end),
    .word_fire  (word_fire),
    .last_word  (last_word)
  );

  refill_banks #(
    .BLOCK_WORDS (BLOCK_WORDS),
    .DATA_W      (DATA_W),
    .BLK_W       (BLK_W),
    .INTERLEAVED (INTERLEAVED)
  ) banks_u (
    .clk     (clk),
    .rst_n   (rst_n),
    .fetch   (access_end),
    .blk     (held_base),
    .idx     (word_idx),
    .rd_data (bank_data)
  );

  refill_penalty_counter #(
    .CNT_W (CNT_W)
  ) pen_u (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .last_cycles (last_cycles)
  );

  assign rd_valid = word_fire;
  assign rd_idx   = word_idx;
  assign rd_data  = word_fire ? bank_data : '0;
  assign done     = word_fire && last_word;

endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int BLOCK_WORDS = 4,
  parameter int BLK_W       = 28,
  parameter int ADDR_CYC    = 1,
  parameter int BANK_LAT    = 15,
  parameter int XFER_CYC    = 1,
  parameter int CNT_W       = 16,
  parameter bit INTERLEAVED = 1'b1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic                           busy,
  input logic                           rd_valid,
  input logic [$clog2(BLOCK_WORDS)-1:0] rd_idx,
  input logic                           done,
  input logic [CNT_W-1:0]               last_cycles,
  input logic [BLK_W-1:0]               held_base
);

  localparam int IDX_W = $clog2(BLOCK_WORDS);
  localparam int EXP_CYC = refill_pkg::refill_cycles(INTERLEAVED, BLOCK_WORDS,
                                                     ADDR_CYC, BANK_LAT, XFER_CYC);

  logic [IDX_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= '0;
    else if (!busy)    seen_q <= '0;
    else if (rd_valid) seen_q <= seen_q + 1'b1;
  end

  // R2 and R3: measured penalty matches the organisation's formula
  p_penalty_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> last_cycles == CNT_W'(EXP_CYC));

  p_word_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_idx == seen_q);

  p_valid_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  p_base_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(held_base));

  p_start_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_last_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_valid && rd_idx == IDX_W'(BLOCK_WORDS - 1)));

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind block_refill_ctrl refill_checker #(
  .BLOCK_WORDS (BLOCK_WORDS),
  .BLK_W       (BLK_W),
  .ADDR_CYC    (ADDR_CYC),
  .BANK_LAT    (BANK_LAT),
  .XFER_CYC    (XFER_CYC),
  .CNT_W       (CNT_W),
  .INTERLEAVED (INTERLEAVED)
) chk_u (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .rd_valid    (rd_valid),
  .rd_idx      (rd_idx),
  .done        (done),
  .last_cycles (last_cycles),
  .held_base   (held_base)
);

// File: tb/block_refill_ctrl_tb_top.sv
`timescale 1ns/1ps
module block_refill_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  // index 0: narrow organisation, index 1: banked organisation
  logic        req_v  [2];
  logic [27:0] req_b  [2];
  logic        busy_o [2];
  logic        val_o  [2];
  logic [1:0]  idx_o  [2];
  logic [31:0] data_o [2];
  logic        done_o [2];
  logic [15:0] pen_o  [2];

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  block_refill_ctrl #(.INTERLEAVED(1'b0)) dut_seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[0]), .req_blk(req_b[0]),
    .busy(busy_o[0]), .rd_valid(val_o[0]), .rd_idx(idx_o[0]),
    .rd_data(data_o[0]), .done(done_o[0]), .last_cycles(pen_o[0]));

  block_refill_ctrl #(.INTERLEAVED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v[1]), .req_blk(req_b[1]),
    .busy(busy_o[1]), .rd_valid(val_o[1]), .rd_idx(idx_o[1]),
    .rd_data(data_o[1]), .done(done_o[1]), .last_cycles(pen_o[1]));

  // {banked, block address}
  localparam logic [28:0] VEC [6] = '{
    {1'b1, 28'd0},
    {1'b0, 28'd0},
    {1'b1, 28'd75},
    {1'b0, 28'd75},
    {1'b1, 28'hFFF_FFFF},
    {1'b0, 28'h123_4567}
  };

  function automatic logic [31:0] model_word(input logic [27:0] b, input int i);
    logic [31:0] w;
    w = {2'b00, b, 2'(i)};
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic int total_cycles(input int m);
    return (m == 1) ? (1 + 15 + 4 * 1) : (1 + 4 * (15 + 1));
  endfunction

  function automatic int word_cycle(input int m, input int i);
    return (m == 1) ? (17 + i) : (17 + 16 * i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic run_refill(input int m, input logic [27:0] b, input bit poke);
    int k;
    int wc;
    int ndone;
    k = 0; wc = 0; ndone = 0;
    @(negedge clk);
    req_v[m] = 1'b1;
    req_b[m] = b;
    @(negedge clk);
    req_v[m] = 1'b0;
    req_b[m] = ~b;
    for (int guard = 0; guard < 200; guard++) begin
      if (!busy_o[m]) break;
      k++;
      if (poke && k == 5) req_v[m] = 1'b1;   // R6 stimulus
      if (poke && k == 8) req_v[m] = 1'b0;
      if (val_o[m]) begin
        chk(k == word_cycle(m, wc), "R5", "word cycle", k, word_cycle(m, wc));
        chk(idx_o[m] == 2'(wc), "R4", "word index", idx_o[m], wc);
        chk(data_o[m] == model_word(b, wc), poke ? "R6" : "R4", "word data",
            data_o[m], model_word(b, wc));
        wc++;
      end
      if (done_o[m]) begin
        ndone++;
        chk(val_o[m] && wc == 4, "R7", "done with last word", wc, 4);
      end
      @(negedge clk);
    end
    chk(k == total_cycles(m), (m == 1) ? "R3" : "R2", "busy cycles", k, total_cycles(m));
    chk(pen_o[m] == 16'(total_cycles(m)), (m == 1) ? "R3" : "R2", "last_cycles",
        pen_o[m], total_cycles(m));
    chk(ndone == 1, "R7", "done pulses", ndone, 1);
    chk(wc == 4, "R4", "words returned", wc, 4);
    chk(!busy_o[m] && k > 0, "R8", "busy low after done", busy_o[m], 0);
    if (poke) begin
      @(negedge clk);
      chk(!busy_o[m], "R6", "no refill from ignored request", busy_o[m], 0);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      req_v[m] = 1'b0;
      req_b[m] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(!busy_o[m] && !val_o[m] && !done_o[m], "R1", "idle in reset", busy_o[m], 0);
      chk(data_o[m] == 0 && pen_o[m] == 0, "R1", "zero outputs in reset", pen_o[m], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      chk(!busy_o[m] && pen_o[m] == 0, "R1", "idle after reset", busy_o[m], 0);

    for (int v = 0; v < 6; v++)
      run_refill(int'(VEC[v][28]), VEC[v][27:0], 1'b0);

    // R6: requests during a refill are ignored, for both organisations
    run_refill(1, 28'h0AB_CDEF, 1'b1);
    run_refill(0, 28'h0AB_CDEF, 1'b1);

    // R8: request in the cycle right after busy falls starts a new refill
    run_refill(1, 28'd7, 1'b0);
    req_v[1] = 1'b1;
    req_b[1] = 28'd9;
    @(negedge clk);
    req_v[1] = 1'b0;
    chk(busy_o[1], "R8", "back-to-back accepted", busy_o[1], 1);
    repeat (25) @(negedge clk);
    chk(!busy_o[1] && pen_o[1] == 16'd20, "R8", "back-to-back length", pen_o[1], 20);

    report();
  end

endmodule